// File: doc/BRIEF.md
# TCM Wait-State Access Controller

This block sits between a processor's tightly coupled memory request port and a synchronous single-port RAM. It turns each request into a RAM strobe and gives the processor a ready handshake. Each access takes either one cycle or two, and reads and writes are set separately. The two-cycle setting is for processor clocks too fast for the RAM to finish an access in a single cycle. In that setting the RAM strobe comes in the second cycle, and address, data and byte enables are taken from a copy captured in the first cycle.

A small control register holds three bits. Bit 0 adds a wait cycle to reads. Bit 1 adds a wait cycle to writes. Bit 2 forces the RAM clock enable on. When bit 2 is clear, the RAM clock enable is raised only while a request is presented or a wait access is in flight. Read data comes back from the RAM in the cycle after the read strobe, and a valid pulse marks it.

Top module: `tcm_wait_ctrl`

## Requirements
- R1: After reset, the control register reads 0 (fast reads, fast writes, no forced clock), and `rsp_ready_o`, `ram_en_o`, `ram_clk_en_o` and `rsp_rvalid_o` are low.
- R2: With control bit 0 clear, a read request raises `rsp_ready_o` and `ram_en_o` in the same cycle, with `ram_we_o` low and `ram_addr_o` equal to the request address. In the next cycle `rsp_rvalid_o` is high and `rsp_rdata_o` carries the RAM output.
- R3: With control bit 1 clear, a write request raises `rsp_ready_o`, `ram_en_o` and `ram_we_o` in the same cycle, and passes the write data and byte enables to the RAM.
- R4: With control bit 0 set, a read holds `rsp_ready_o` and `ram_en_o` low in its first cycle. Both are high in its second cycle, and the controller is idle again after that.
- R5: With control bit 1 set, a write behaves as in R4, with `ram_we_o` high in the second cycle.
- R6: The read-wait and write-wait bits act independently. A set write-wait bit leaves reads at one cycle, and a set read-wait bit leaves writes at one cycle.
- R7: In the second cycle of a wait access, the RAM address, write data, byte enables and direction equal the values presented in the first cycle, even if the request inputs change.
- R8: A control write takes effect on the cycle after it. A write landing in either cycle of an access leaves that access's length unchanged, and the new setting governs the next access.
- R9: With bit 2 clear, `ram_clk_en_o` is high exactly when a request is presented or a wait access is in its second cycle, and low when idle.
- R10: With bit 2 set, `ram_clk_en_o` stays high while idle.
- R11: Back-to-back one-cycle accesses complete at one per cycle, and each read's data returns in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control value: bit0 read wait, bit1 write wait, bit2 force clock |
| ctrl_o | output | 3 | Current control register value |
| req_valid_i | input | 1 | Request presented; held until ready |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte enables |
| rsp_ready_o | output | 1 | Access completes this cycle |
| rsp_rvalid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DW | Read data |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_be_o | output | DW/8 | RAM byte enables |
| ram_rdata_i | input | DW | RAM read data, registered inside the RAM |
| ram_clk_en_o | output | 1 | RAM clock enable |

## Verification
Two things can happen in the same cycle: a control register write and an access whose length depends on that register. The bench writes a wait bit in the first cycle of a one-cycle read and in the second cycle of a two-cycle read. It then checks that `rsp_ready_o` still comes in the cycle set by the old value, and that the very next request uses the new value. Wait accesses also change the request inputs in their second cycle, and the bench checks that the RAM still sees the first-cycle values.

// File: rtl/tcm_wait_pkg.sv
`timescale 1ns/1ps
package tcm_wait_pkg;
  localparam int unsigned CTRL_W = 3;

  // bit2 force clock, bit1 write wait, bit0 read wait
  typedef struct packed {
    logic force_clk;
    logic wwait;
    logic rwait;
  } tcm_ctrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tcm_state_e;
endpackage

// File: rtl/tcm_ctrl_reg.sv
`timescale 1ns/1ps
module tcm_ctrl_reg
  import tcm_wait_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output tcm_ctrl_t         ctrl_o
);
  tcm_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= tcm_ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q)) else $error("ctrl changed without write"); // R8
endmodule

// File: rtl/tcm_access_fsm.sv
`timescale 1ns/1ps
module tcm_access_fsm
  import tcm_wait_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tcm_ctrl_t     ctrl_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [BW-1:0] req_be_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          rvalid_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic [BW-1:0] ram_be_o
);
  tcm_state_e    state_q, state_d;
  logic          wait_sel, cap_en;
  logic          write_q, rvalid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] be_q;

  assign wait_sel = req_write_i ? ctrl_i.wwait : ctrl_i.rwait;
  assign cap_en   = (state_q == ST_IDLE) && req_valid_i && wait_sel;

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = req_addr_i;
    ram_wdata_o = req_wdata_i;
    ram_be_o    = req_be_i;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (wait_sel) begin
            state_d = ST_WAIT;
          end else begin
            ready_o  = 1'b1;
            ram_en_o = 1'b1;
            ram_we_o = req_write_i;
          end
        end
      end
      ST_WAIT: begin
        ready_o     = 1'b1;
        ram_en_o    = 1'b1;
        ram_we_o    = write_q;
        ram_addr_o  = addr_q;
        ram_wdata_o = wdata_q;
        ram_be_o    = be_q;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= ram_en_o && !ram_we_o;
    end
  end

  // first-cycle copy so the RAM sees steady inputs in the strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (cap_en) begin
      write_q <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  assign busy_o   = (state_q == ST_WAIT);
  assign rvalid_o = rvalid_q;

  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |=> state_q == ST_IDLE) else $error("wait too long"); // R4
  AST_WAIT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !$past(ready_o)) else $error("ready in first wait cycle"); // R5
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> ram_addr_o == $past(req_addr_i) && ram_we_o == $past(req_write_i))
    else $error("wait address not held"); // R7
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o && !ram_we_o |=> rvalid_o) else $error("missing rvalid"); // R2
  AST_READY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && state_q == ST_IDLE |-> req_valid_i) else $error("spurious ready"); // R11
endmodule

// File: rtl/tcm_clk_gate.sv
`timescale 1ns/1ps
module tcm_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic req_valid_i,
  input  logic busy_i,
  input  logic ram_en_i,
  output logic clk_en_o
);
  assign clk_en_o = force_i || req_valid_i || busy_i;

  AST_EN_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_i |-> clk_en_o) else $error("strobe with clock gated"); // R9
  AST_FORCE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> clk_en_o) else $error("forced clock dropped"); // R10
endmodule

// File: rtl/tcm_wait_ctrl.sv
`timescale 1ns/1ps
module tcm_wait_ctrl
  import tcm_wait_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [BW-1:0]     req_be_i,
  output logic              rsp_ready_o,
  output logic              rsp_rvalid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  output logic [BW-1:0]     ram_be_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              ram_clk_en_o
);
  tcm_ctrl_t ctrl;
  logic      busy;

  tcm_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  tcm_access_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .ready_o     (rsp_ready_o),
    .busy_o      (busy),
    .rvalid_o    (rsp_rvalid_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_be_o    (ram_be_o)
  );

  tcm_clk_gate u_cg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_i     (ctrl.force_clk),
    .req_valid_i (req_valid_i),
    .busy_i      (busy),
    .ram_en_i    (ram_en_o),
    .clk_en_o    (ram_clk_en_o)
  );

  assign ctrl_o      = ctrl;
  assign rsp_rdata_o = ram_rdata_i;

  AST_CTRL_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_o == $past(ctrl_wdata_i)) else $error("ctrl write lost"); // R8
endmodule

// File: tb/tcm_wait_ctrl_bench.sv
`timescale 1ns/1ps
module tcm_wait_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [2:0]    ctrl_wdata = '0;
  logic [2:0]    ctrl_rd;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic          rsp_ready, rsp_rvalid;
  logic [DW-1:0] rsp_rdata;
  logic          ram_en, ram_we, ram_clk_en;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [BW-1:0] ram_be;
  logic [DW-1:0] ram_rd_q = '0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  // RAM model: registered read returning a tag plus the address
  always @(posedge clk) if (ram_en && !ram_we) ram_rd_q <= {16'hC0DE, ram_addr};

  tcm_wait_ctrl #(.AW(AW), .DW(DW)) u_tcm_wait_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_rd),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_ready_o(rsp_ready), .rsp_rvalid_o(rsp_rvalid), .rsp_rdata_o(rsp_rdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_be_o(ram_be), .ram_rdata_i(ram_rd_q),
    .ram_clk_en_o(ram_clk_en)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [2:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "ctrl", ctrl_rd, 0);
    chk("R1", "ready", rsp_ready, 0);
    chk("R1", "en", ram_en, 0);
    chk("R1", "clk_en", ram_clk_en, 0);
    chk("R1", "rvalid", rsp_rvalid, 0);
  endtask

  task automatic t_fast_read(input logic [AW-1:0] a);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a; #1;
    chk("R2", "ready", rsp_ready, 1);
    chk("R2", "en", ram_en, 1);
    chk("R2", "we", ram_we, 0);
    chk("R2", "addr", ram_addr, a);
    @(negedge clk); idle_req(); #1;
    chk("R2", "rvalid", rsp_rvalid, 1);
    chk("R2", "rdata", rsp_rdata, exp_rd(a));
  endtask

  task automatic t_fast_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be; #1;
    chk("R3", "ready", rsp_ready, 1);
    chk("R3", "en", ram_en, 1);
    chk("R3", "we", ram_we, 1);
    chk("R3", "wdata", ram_wdata, d);
    chk("R3", "be", ram_be, be);
    @(negedge clk); idle_req(); #1;
    chk("R3", "rvalid", rsp_rvalid, 0);
  endtask

  task automatic t_wait_read(input logic [AW-1:0] a);
    set_ctrl(3'b001);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a; #1;
    chk("R4", "ready c1", rsp_ready, 0);
    chk("R4", "en c1", ram_en, 0);
    chk("R9", "clk_en c1", ram_clk_en, 1);
    @(negedge clk); req_addr = ~a; #1;
    chk("R4", "ready c2", rsp_ready, 1);
    chk("R4", "en c2", ram_en, 1);
    chk("R7", "addr held", ram_addr, a);
    @(negedge clk); idle_req(); #1;
    chk("R4", "rvalid", rsp_rvalid, 1);
    chk("R4", "rdata", rsp_rdata, exp_rd(a));
    chk("R4", "idle ready", rsp_ready, 0);
  endtask

  task automatic t_wait_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    set_ctrl(3'b010);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be; #1;
    chk("R5", "ready c1", rsp_ready, 0);
    chk("R5", "en c1", ram_en, 0);
    @(negedge clk); req_wdata = ~d; req_be = ~be; req_addr = a + 1; req_write = 0; #1;
    chk("R5", "ready c2", rsp_ready, 1);
    chk("R5", "we c2", ram_we, 1);
    chk("R7", "wdata held", ram_wdata, d);
    chk("R7", "be held", ram_be, be);
    chk("R7", "addr held", ram_addr, a);
    @(negedge clk); idle_req(); #1;
  endtask

  task automatic t_independent();
    set_ctrl(3'b010);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 16'h0042; #1;
    chk("R6", "read fast under wwait", rsp_ready, 1);
    @(negedge clk); idle_req();
    set_ctrl(3'b001);
    @(negedge clk); req_valid = 1; req_write = 1; req_wdata = 32'h1234_5678; req_be = 4'hF; #1;
    chk("R6", "write fast under rwait", rsp_ready, 1);
    chk("R6", "write strobe", ram_we, 1);
    @(negedge clk); idle_req();
  endtask

  task automatic t_boundary();
    set_ctrl(3'b001);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 16'h0100; #1;
    chk("R8", "wait c1", rsp_ready, 0);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 3'b000; #1;
    chk("R8", "wait c2 still completes", rsp_ready, 1);
    @(negedge clk); ctrl_we = 0; req_addr = 16'h0101; #1;
    chk("R8", "ctrl readback", ctrl_rd, 0);
    chk("R8", "next read fast", rsp_ready, 1);
    @(negedge clk); idle_req();
    @(negedge clk); req_valid = 1; req_addr = 16'h0102; ctrl_we = 1; ctrl_wdata = 3'b001; #1;
    chk("R8", "fast despite same-cycle write", rsp_ready, 1);
    @(negedge clk); ctrl_we = 0; req_addr = 16'h0103; #1;
    chk("R8", "next read waits", rsp_ready, 0);
    @(negedge clk); #1;
    chk("R8", "next read completes", rsp_ready, 1);
    @(negedge clk); idle_req();
  endtask

  task automatic t_clk_gate();
    set_ctrl(3'b000);
    @(negedge clk); #1;
    chk("R9", "idle gated", ram_clk_en, 0);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 16'h0200; #1;
    chk("R9", "request opens", ram_clk_en, 1);
    @(negedge clk); idle_req(); #1;
    chk("R9", "idle again", ram_clk_en, 0);
  endtask

  task automatic t_force();
    set_ctrl(3'b100);
    @(negedge clk); #1;
    chk("R10", "ctrl readback", ctrl_rd, 3'b100);
    chk("R10", "forced idle", ram_clk_en, 1);
    @(negedge clk); #1;
    chk("R10", "still forced", ram_clk_en, 1);
    set_ctrl(3'b000);
  endtask

  task automatic t_b2b();
    set_ctrl(3'b000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); req_valid = 1; req_write = 0; req_addr = 16'h0300 + 16'(i); #1;
      chk("R11", "ready each cycle", rsp_ready, 1);
      if (i > 0) begin
        chk("R11", "rvalid", rsp_rvalid, 1);
        chk("R11", "rdata", rsp_rdata, exp_rd(16'h0300 + 16'(i - 1)));
      end
    end
    @(negedge clk); idle_req(); #1;
    chk("R11", "last rdata", rsp_rdata, exp_rd(16'h0303));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_fast_read(16'h0010);
    t_fast_write(16'h0020, 32'hDEAD_BEEF, 4'b0101);
    t_wait_read(16'h0030);
    t_wait_write(16'h0040, 32'hCAFE_F00D, 4'b1100);
    t_independent();
    t_boundary();
    t_clk_gate();
    t_force();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule